// File: doc/BRIEF.md
# Vector Element Step Controller

This block keeps the loop state of a register-file vector extension. The state is a vector length, a maximum vector length, a source element index, a destination element index and a vertical-first mode flag. Every cycle it turns operand descriptors into physical register numbers. An operand marked as a vector is offset by the matching element index, modulo the register count. An operand marked as scalar keeps its own register number.

The state can be written in full through a load port. A set-length command writes only the length and the mode flag. A step command moves both element indices forward by one, but only in vertical-first mode. When either index would reach the length, the command ends the loop. It clears both indices, drops vertical-first mode and returns a 4-bit condition result with only the summary-overflow bit set. Translation is purely combinational. Load, set-length and step are single-cycle control pulses with no back-pressure. Each accepted step produces a one-cycle `cr_valid` pulse on the next cycle.

Top module: `vstep_ctrl`

## Requirements
- R1: After reset, `vl`, `maxvl`, `src_step` and `dst_step` are 0, `vf_mode` is 0, `cr_valid` is 0 and `cr_out` is 0.
- R2: A `load_en` pulse writes length, maximum length, both element indices and the mode flag from the load inputs on the next edge. It takes priority over a set-length command and over a step request in the same cycle. The step is then dropped and gives no `cr_valid` pulse.
- R3: A `setvl_en` pulse writes `vl` and `vf_mode` and leaves `maxvl` and both indices untouched. It takes priority over a step request in the same cycle, which is dropped.
- R4: A vector source operand with base B maps to (B + `src_step`) mod 32. A vector destination with base D maps to (D + `dst_step`) mod 32.
- R5: A scalar operand (its vector flag is 0) maps to its own base register number, whatever the element indices hold.
- R6: An accepted step in vertical-first mode that does not end the loop adds 1 to both indices and keeps `vf_mode` set. `cr_valid` is then high for one cycle with `cr_out` = 4'b0000.
- R7: A step ends the loop when the incremented source index or the incremented destination index equals `vl`. In that case both indices become 0 and `vf_mode` becomes 0. `cr_out` = 4'b0001, where bit 0 is summary overflow and bits 3..1 are less-than, greater-than and equal, all 0.
- R8: A step command never changes `vl` or `maxvl`.
- R9: A step request while `vf_mode` is 0 leaves both indices and the mode unchanged. It still gives a one-cycle `cr_valid` pulse with `cr_out` = 4'b0000.
- R10: When no command is present, the element indices hold their values from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write the whole loop state |
| load_vl | input | 7 | Length to load |
| load_maxvl | input | 7 | Maximum length to load |
| load_src | input | 7 | Source index to load |
| load_dst | input | 7 | Destination index to load |
| load_vf | input | 1 | Mode flag to load |
| setvl_en | input | 1 | Set-length command |
| setvl_vl | input | 7 | Length for set-length |
| setvl_vf | input | 1 | Mode flag for set-length |
| step_req | input | 1 | Explicit step command |
| src_base | input | 10 | Two 5-bit source base registers, operand 0 in bits 4:0 |
| src_vec | input | 2 | Vector flag per source operand |
| dst_base | input | 5 | Destination base register |
| dst_vec | input | 1 | Vector flag of the destination |
| src_phys | output | 10 | Translated source registers, operand 0 in bits 4:0 |
| dst_phys | output | 5 | Translated destination register |
| vl | output | 7 | Current length |
| maxvl | output | 7 | Current maximum length |
| src_step | output | 7 | Current source index |
| dst_step | output | 7 | Current destination index |
| vf_mode | output | 1 | Vertical-first mode flag |
| cr_out | output | 4 | Condition result of the last step |
| cr_valid | output | 1 | One-cycle pulse after each accepted step |

## Verification
The hardest case to reach is a loop end decided by the destination index while the source index is still far from the length. That only happens after a load leaves the two indices unequal, followed by enough steps. The stimulus loads length 5 with indices 0 and 3 in vertical-first mode and then steps twice. It also drives commands in the same cycle to exercise the load > set-length > step priority. It drives steps with the mode off, so the ignored-step result shows at the ports.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  localparam int CR_W  = 4;
  localparam int CR_SO = 0;
  localparam int CR_EQ = 1;
  localparam int CR_GT = 2;
  localparam int CR_LT = 3;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SETVL = 2'd2,
    ACT_STEP  = 2'd3
  } act_e;
endpackage

// File: rtl/vstep_arb.sv
module vstep_arb
  import vstep_pkg::*;
(
  input  logic load_en,
  input  logic setvl_en,
  input  logic step_req,
  output act_e act
);
  always_comb begin
    if (load_en)       act = ACT_LOAD;
    else if (setvl_en) act = ACT_SETVL;
    else if (step_req) act = ACT_STEP;
    else               act = ACT_NONE;
  end
endmodule

// File: rtl/vstep_xlate.sv
module vstep_xlate #(
  parameter int REG_W  = 5,
  parameter int STEP_W = 7
) (
  input  logic [REG_W-1:0]  base,
  input  logic              is_vec,
  input  logic [STEP_W-1:0] step,
  output logic [REG_W-1:0]  phys
);
  logic [REG_W-1:0] offs;
  assign offs = step[REG_W-1:0];
  assign phys = is_vec ? base + offs : base;
endmodule

// File: rtl/vstep_state.sv
module vstep_state
  import vstep_pkg::*;
#(
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic [STEP_W-1:0] load_vl,
  input  logic [STEP_W-1:0] load_maxvl,
  input  logic [STEP_W-1:0] load_src,
  input  logic [STEP_W-1:0] load_dst,
  input  logic              load_vf,
  input  logic [STEP_W-1:0] setvl_vl,
  input  logic              setvl_vf,
  output logic [STEP_W-1:0] vl,
  output logic [STEP_W-1:0] maxvl,
  output logic [STEP_W-1:0] src_step,
  output logic [STEP_W-1:0] dst_step,
  output logic              vf_mode,
  output logic [CR_W-1:0]   cr_out,
  output logic              cr_valid
);
  localparam logic [CR_W-1:0] CR_END = CR_W'(1) << CR_SO;

  logic [STEP_W:0] src_nx, dst_nx;
  logic            loop_end;

  assign src_nx   = {1'b0, src_step} + 1'b1;
  assign dst_nx   = {1'b0, dst_step} + 1'b1;
  assign loop_end = (src_nx == {1'b0, vl}) || (dst_nx == {1'b0, vl});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl       <= '0;
      maxvl    <= '0;
      src_step <= '0;
      dst_step <= '0;
      vf_mode  <= 1'b0;
      cr_out   <= '0;
      cr_valid <= 1'b0;
    end else begin
      cr_valid <= 1'b0;
      unique case (act)
        ACT_LOAD: begin
          vl       <= load_vl;
          maxvl    <= load_maxvl;
          src_step <= load_src;
          dst_step <= load_dst;
          vf_mode  <= load_vf;
        end
        ACT_SETVL: begin
          vl      <= setvl_vl;
          vf_mode <= setvl_vf;
        end
        ACT_STEP: begin
          cr_valid <= 1'b1;
          cr_out   <= '0;
          if (vf_mode) begin
            if (loop_end) begin
              src_step <= '0;
              dst_step <= '0;
              vf_mode  <= 1'b0;
              cr_out   <= CR_END;
            end else begin
              src_step <= src_nx[STEP_W-1:0];
              dst_step <= dst_nx[STEP_W-1:0];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_load_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_LOAD |=> vl == $past(load_vl) && src_step == $past(load_src)
                        && dst_step == $past(load_dst) && vf_mode == $past(load_vf));

  assert_step_keeps_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_STEP |=> $stable(vl) && $stable(maxvl));

  assert_end_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid && cr_out[CR_SO] |-> src_step == '0 && dst_step == '0 && !vf_mode);

  assert_cr_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> $countones(cr_out) <= 1 && !cr_out[CR_LT] && !cr_out[CR_GT] && !cr_out[CR_EQ]);

  assert_ignored_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_STEP && !vf_mode |=> $stable(src_step) && $stable(dst_step) && cr_out == '0);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_NONE |=> $stable(src_step) && $stable(dst_step) && !cr_valid);
endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
  import vstep_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int STEP_W  = 7,
  parameter int NUM_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [STEP_W-1:0]        load_vl,
  input  logic [STEP_W-1:0]        load_maxvl,
  input  logic [STEP_W-1:0]        load_src,
  input  logic [STEP_W-1:0]        load_dst,
  input  logic                     load_vf,
  input  logic                     setvl_en,
  input  logic [STEP_W-1:0]        setvl_vl,
  input  logic                     setvl_vf,
  input  logic                     step_req,
  input  logic [NUM_SRC*REG_W-1:0] src_base,
  input  logic [NUM_SRC-1:0]       src_vec,
  input  logic [REG_W-1:0]         dst_base,
  input  logic                     dst_vec,
  output logic [NUM_SRC*REG_W-1:0] src_phys,
  output logic [REG_W-1:0]         dst_phys,
  output logic [STEP_W-1:0]        vl,
  output logic [STEP_W-1:0]        maxvl,
  output logic [STEP_W-1:0]        src_step,
  output logic [STEP_W-1:0]        dst_step,
  output logic                     vf_mode,
  output logic [CR_W-1:0]          cr_out,
  output logic                     cr_valid
);
  act_e act;

  vstep_arb u_arb (
    .load_en (load_en),
    .setvl_en(setvl_en),
    .step_req(step_req),
    .act     (act)
  );

  vstep_state #(.STEP_W(STEP_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .load_vl   (load_vl),
    .load_maxvl(load_maxvl),
    .load_src  (load_src),
    .load_dst  (load_dst),
    .load_vf   (load_vf),
    .setvl_vl  (setvl_vl),
    .setvl_vf  (setvl_vf),
    .vl        (vl),
    .maxvl     (maxvl),
    .src_step  (src_step),
    .dst_step  (dst_step),
    .vf_mode   (vf_mode),
    .cr_out    (cr_out),
    .cr_valid  (cr_valid)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    vstep_xlate #(.REG_W(REG_W), .STEP_W(STEP_W)) u_xs (
      .base  (src_base[i*REG_W +: REG_W]),
      .is_vec(src_vec[i]),
      .step  (src_step),
      .phys  (src_phys[i*REG_W +: REG_W])
    );
  end

  vstep_xlate #(.REG_W(REG_W), .STEP_W(STEP_W)) u_xd (
    .base  (dst_base),
    .is_vec(dst_vec),
    .step  (dst_step),
    .phys  (dst_phys)
  );
endmodule

// File: tb/tb_vstep_ctrl.sv
module tb_vstep_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       load_en = 0, setvl_en = 0, step_req = 0, load_vf = 0, setvl_vf = 0;
  logic [6:0] load_vl = 0, load_maxvl = 0, load_src = 0, load_dst = 0, setvl_vl = 0;
  logic [9:0] src_base = 0;
  logic [1:0] src_vec = 0;
  logic [4:0] dst_base = 0;
  logic       dst_vec = 0;
  logic [9:0] src_phys;
  logic [4:0] dst_phys;
  logic [6:0] vl, maxvl, src_step, dst_step;
  logic       vf_mode, cr_valid;
  logic [3:0] cr_out;

  vstep_ctrl dut (.*);

  int checks = 0, errors = 0;
  int m_vl = 0, m_max = 0, m_src = 0, m_dst = 0, m_vf = 0, m_cr = 0, m_crv = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R8", "vl", int'(vl), m_vl);
    chk("R8", "maxvl", int'(maxvl), m_max);
    chk("R10", "src_step", int'(src_step), m_src);
    chk("R10", "dst_step", int'(dst_step), m_dst);
    chk("R7", "vf_mode", int'(vf_mode), m_vf);
    chk("R6", "cr_valid", int'(cr_valid), m_crv);
    if (m_crv) chk("R7", "cr_out", int'(cr_out), m_cr);
    for (int i = 0; i < 2; i++)
      chk(src_vec[i] ? "R4" : "R5", "src_phys", int'(src_phys[i*5 +: 5]),
          src_vec[i] ? (int'(src_base[i*5 +: 5]) + m_src) % 32 : int'(src_base[i*5 +: 5]));
    chk(dst_vec ? "R4" : "R5", "dst_phys", int'(dst_phys),
        dst_vec ? (int'(dst_base) + m_dst) % 32 : int'(dst_base));
  endtask

  // one clock: inputs already set at a negedge; update model, compare at next negedge
  task automatic tick();
    int ns, nd;
    m_crv = 0;
    if (load_en) begin
      m_vl = load_vl; m_max = load_maxvl; m_src = load_src; m_dst = load_dst; m_vf = load_vf;
    end else if (setvl_en) begin
      m_vl = setvl_vl; m_vf = setvl_vf;
    end else if (step_req) begin
      m_crv = 1; m_cr = 0;
      if (m_vf != 0) begin
        ns = m_src + 1; nd = m_dst + 1;
        if (ns == m_vl || nd == m_vl) begin
          m_src = 0; m_dst = 0; m_vf = 0; m_cr = 1;
        end else begin
          m_src = ns % 128; m_dst = nd % 128;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
    load_en = 0; setvl_en = 0; step_req = 0;
  endtask

  task automatic do_load(int l, int mx, int s, int d, int f);
    load_en = 1; load_vl = 7'(l); load_maxvl = 7'(mx); load_src = 7'(s);
    load_dst = 7'(d); load_vf = f[0];
  endtask

  task automatic set_ops(int b0, int v0, int b1, int v1, int bd, int vd);
    src_base = {5'(b1), 5'(b0)}; src_vec = {v1[0], v0[0]};
    dst_base = 5'(bd); dst_vec = vd[0];
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_ops(5, 1, 9, 1, 1, 0);
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", "vl", int'(vl), 0);
    chk("R1", "vf_mode", int'(vf_mode), 0);
    chk("R1", "cr_valid", int'(cr_valid), 0);
    chk("R1", "cr_out", int'(cr_out), 0);
    chk("R1", "src_step", int'(src_step), 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R4/R5: direct load of steps 1, scalar destination stays at r1
    do_load(2, 2, 1, 1, 0); tick();
    tick();
    // R9: step with mode off is ignored
    step_req = 1; tick();
    tick();
    // R3: set-length turns on vertical-first, keeps maxvl and steps
    do_load(2, 2, 0, 0, 0); tick();
    setvl_en = 1; setvl_vl = 2; setvl_vf = 1; tick();
    repeat (3) tick();   // R10: idle holds steps
    // R6 then R7: two steps over length 2
    step_req = 1; tick();
    set_ops(5, 1, 9, 0, 12, 1); tick();
    step_req = 1; tick();
    tick();
    // R2 priority: load beats step and set-length
    do_load(6, 8, 2, 2, 1); step_req = 1; setvl_en = 1; setvl_vl = 3; tick();
    // R3 priority: set-length beats step
    setvl_en = 1; setvl_vl = 4; setvl_vf = 1; step_req = 1; tick();
    // R4 wrap modulo 32
    do_load(40, 40, 5, 7, 1); set_ops(30, 1, 31, 1, 29, 1); tick();
    repeat (4) begin step_req = 1; tick(); end
    // R7 end decided by destination index
    do_load(5, 5, 0, 3, 1); set_ops(1, 1, 2, 0, 3, 1); tick();
    step_req = 1; tick();
    step_req = 1; tick();
    step_req = 1; tick();   // R9 after end
    // back-to-back steps over a longer loop
    do_load(4, 4, 0, 0, 1); tick();
    repeat (5) begin step_req = 1; tick(); end
    // R1: reset returns everything to zero
    rst_n = 0;
    m_vl = 0; m_max = 0; m_src = 0; m_dst = 0; m_vf = 0; m_crv = 0; m_cr = 0;
    @(negedge clk);
    compare_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule